// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This block turns a compact 13-bit logical-immediate code into the 64-bit constant it stands for. The code has three fields: a single size-extension bit, a 6-bit run-length field and a 6-bit rotate field. The decoder builds the 7-bit value made of the size-extension bit above the inverted run-length field and finds its highest set bit. That bit position picks an element size of 2, 4, 8, 16, 32 or 64 bits. Inside one element the decoder places a run of consecutive ones starting at bit zero. It rotates that run to the right within the element and then copies the element across the whole 64-bit word.

An instruction decode stage feeds the three fields, a valid strobe and a 32-bit-mode flag, and receives the expanded constant one clock later. A reserved flag comes with the constant and marks codes that must not be executed. The pattern output is still produced for most reserved codes, so that a caller can see what was decoded.

Top module: `bmi_decoder`

## Requirements
- R1: The element size is 2^k, where k is the index of the highest set bit of the 7-bit value {size_hi, ~run_len_code} (size_hi is bit 6).
- R2: With a rotate of zero, each element holds s+1 ones in its lowest bits and zeros above them, where s = run_len_code AND (element size − 1).
- R3: The run is rotated right by r = rot_code AND (element size − 1) within the element, so element bit i takes the unrotated bit (i + r) mod element size.
- R4: Output bit b equals element bit (b mod element size) for all 64 bits.
- R5: When s+1 equals the element size, the element is all ones, and for a 64-bit element the whole word is all ones.
- R6: When narrow_mode is 1, pattern_o[63:32] is zero and pattern_o[31:0] is unchanged.
- R7: When the 7-bit value is zero or equal to 1 (no element size of 2 or more), reserved_o is 1 and pattern_o is zero.
- R8: reserved_o is 1 when s equals element size − 1 (an all-ones element).
- R9: reserved_o is 1 when narrow_mode is 1 and size_hi is 1.
- R10: Results appear one clock after a cycle with in_valid high, and out_valid is in_valid delayed by one clock. Reset clears out_valid, pattern_o and reserved_o to zero.
- R11: In a cycle with in_valid low, pattern_o and reserved_o keep their values on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The code fields are valid this cycle |
| size_hi | input | 1 | Size-extension bit of the code |
| run_len_code | input | 6 | Run-length field |
| rot_code | input | 6 | Rotate field |
| narrow_mode | input | 1 | 32-bit result mode |
| out_valid | output | 1 | Registered result is fresh |
| pattern_o | output | 64 | Expanded constant |
| reserved_o | output | 1 | Code is not allowed |

## Verification
A wrong element-size choice changes the period of the whole word. A wrong run length or rotate shifts or widens every copy, so a single fault shows up in many output bits at once. Each wrong value is visible at pattern_o in the very next cycle after the code is presented, because no state carries over from one code to the next. The only exception is the held value when in_valid is low. The bench therefore checks every one of the 8192 codes in both modes against a bit-by-bit model, one per clock. It adds directed codes for the boundaries: the smallest element, a 64-bit run, a zero rotate, narrow-mode truncation and the hold cycles.

// File: rtl/bmi_pkg.sv
package bmi_pkg;

    localparam int DATA_W    = 64;
    localparam int FIELD_W   = 6;
    localparam int CODE_W    = FIELD_W + 1;
    localparam int LEN_W     = $clog2(CODE_W);
    localparam int NUM_SIZES = FIELD_W;

    typedef struct packed {
        logic              valid;
        logic              reserved;
        logic [DATA_W-1:0] mask;
    } bmi_state_t;

endpackage

// File: rtl/bmi_size_detect.sv
module bmi_size_detect #(
    parameter int FIELD_W = bmi_pkg::FIELD_W,
    parameter int LEN_W   = bmi_pkg::LEN_W
) (
    input  logic               size_hi,
    input  logic [FIELD_W-1:0] run_len_code,
    output logic               found,
    output logic [LEN_W-1:0]   len,
    output logic [FIELD_W-1:0] levels
);

    localparam int CODE_W = FIELD_W + 1;

    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] span;

    assign code = {size_hi, ~run_len_code};

    // Highest set bit wins: scan upward and keep the last hit.
    always_comb begin
        found = 1'b0;
        len   = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (code[i]) begin
                found = 1'b1;
                len   = LEN_W'(i);
            end
        end
    end

    always_comb begin
        span   = (CODE_W'(1) << len) - CODE_W'(1);
        levels = span[FIELD_W-1:0];
    end

endmodule

// File: rtl/bmi_elem_rotate.sv
module bmi_elem_rotate #(
    parameter int ESIZE   = 8,
    parameter int FIELD_W = bmi_pkg::FIELD_W
) (
    input  logic [FIELD_W-1:0] run_amt,
    input  logic [FIELD_W-1:0] rot_amt,
    output logic [ESIZE-1:0]   elem
);

    logic [ESIZE-1:0]   ones;
    logic [2*ESIZE-1:0] doubled;
    logic [2*ESIZE-1:0] shifted;

    // Bit-by-bit compare: a run of the full element needs no shift that overflows.
    always_comb begin
        for (int i = 0; i < ESIZE; i++) begin
            ones[i] = (FIELD_W'(i) <= run_amt);
        end
    end

    // Two copies side by side turn a rotate into one right shift; a zero rotate is a pass-through.
    always_comb begin
        doubled = {ones, ones};
        shifted = doubled >> rot_amt;
        elem    = shifted[ESIZE-1:0];
    end

endmodule

// File: rtl/bmi_replicate.sv
module bmi_replicate #(
    parameter int DATA_W = bmi_pkg::DATA_W,
    parameter int ESIZE  = 8
) (
    input  logic [ESIZE-1:0]  elem,
    output logic [DATA_W-1:0] word
);

    localparam int COPIES = DATA_W / ESIZE;

    for (genvar j = 0; j < COPIES; j++) begin : g_copy
        assign word[j*ESIZE +: ESIZE] = elem;
    end

endmodule

// File: rtl/bmi_decoder.sv
module bmi_decoder
    import bmi_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          size_hi,
    input  logic [FW-1:0] run_len_code,
    input  logic [FW-1:0] rot_code,
    input  logic          narrow_mode,
    output logic          out_valid,
    output logic [DW-1:0] pattern_o,
    output logic          reserved_o
);

    localparam int HALF_W = DW / 2;
    localparam int NSIZE  = FW;
    localparam int LW     = $clog2(FW + 1);

    typedef struct packed {
        logic          valid;
        logic          reserved;
        logic [DW-1:0] mask;
    } dec_state_t;

    dec_state_t state_d, state_q;

    logic          size_found;
    logic [LW-1:0] size_len;
    logic [FW-1:0] size_levels;
    logic [DW-1:0] size_pat [NSIZE+1];

    bmi_size_detect #(
        .FIELD_W (FW),
        .LEN_W   (LW)
    ) u_size (
        .size_hi      (size_hi),
        .run_len_code (run_len_code),
        .found        (size_found),
        .len          (size_len),
        .levels       (size_levels)
    );

    assign size_pat[0] = '0;

    // One candidate pattern per legal element size; the detected size picks one.
    for (genvar k = 1; k <= NSIZE; k++) begin : g_size
        localparam int ESIZE = 1 << k;
        localparam logic [FW-1:0] LVL = FW'(ESIZE - 1);

        logic [ESIZE-1:0] elem;

        bmi_elem_rotate #(
            .ESIZE   (ESIZE),
            .FIELD_W (FW)
        ) u_elem (
            .run_amt (run_len_code & LVL),
            .rot_amt (rot_code & LVL),
            .elem    (elem)
        );

        bmi_replicate #(
            .DATA_W (DW),
            .ESIZE  (ESIZE)
        ) u_rep (
            .elem (elem),
            .word (size_pat[k])
        );
    end

    always_comb begin
        logic [DW-1:0] sel;
        state_d       = state_q;
        state_d.valid = in_valid;
        sel           = '0;
        if (in_valid) begin
            if (size_found && (size_len != '0)) begin
                sel = size_pat[size_len];
            end
            if (narrow_mode) begin
                sel[DW-1:HALF_W] = '0;
            end
            state_d.mask     = sel;
            state_d.reserved = !size_found
                            || (size_len == '0)
                            || (narrow_mode && size_hi)
                            || ((run_len_code & size_levels) == size_levels);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid  = state_q.valid;
    assign pattern_o  = state_q.mask;
    assign reserved_o = state_q.reserved;

endmodule

// File: rtl/bmi_decoder_checker.sv
module bmi_decoder_checker #(
    parameter int DW = 64,
    parameter int FW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          size_hi,
    input logic [FW-1:0] run_len_code,
    input logic [FW-1:0] rot_code,
    input logic          narrow_mode,
    input logic          out_valid,
    input logic [DW-1:0] pattern_o,
    input logic          reserved_o
);

    localparam int HALF_W = DW / 2;

    p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pattern_o) && $stable(reserved_o)));

    p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow_mode) |=> (pattern_o[DW-1:HALF_W] == '0));

    p_narrow_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow_mode && size_hi) |=> reserved_o);

    p_no_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !size_hi && (run_len_code[FW-1:1] == '1)) |=> (reserved_o && (pattern_o == '0)));

    p_full_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_hi && !narrow_mode && (run_len_code == '1)) |=> ((pattern_o == '1) && reserved_o));

    p_zero_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_hi && !narrow_mode && (rot_code == '0)) |=> pattern_o[0]);

endmodule

bind bmi_decoder bmi_decoder_checker #(
    .DW (DW),
    .FW (FW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .size_hi      (size_hi),
    .run_len_code (run_len_code),
    .rot_code     (rot_code),
    .narrow_mode  (narrow_mode),
    .out_valid    (out_valid),
    .pattern_o    (pattern_o),
    .reserved_o   (reserved_o)
);

// File: tb/bmi_decoder_test.sv
`timescale 1ns/1ps
module bmi_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        size_hi = 1'b0;
    logic [5:0]  run_len_code = '0;
    logic [5:0]  rot_code = '0;
    logic        narrow_mode = 1'b0;
    logic        out_valid;
    logic [63:0] pattern_o;
    logic        reserved_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bmi_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .size_hi      (size_hi),
        .run_len_code (run_len_code),
        .rot_code     (rot_code),
        .narrow_mode  (narrow_mode),
        .out_valid    (out_valid),
        .pattern_o    (pattern_o),
        .reserved_o   (reserved_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: bit-by-bit from the requirement text.
    task automatic model(input logic n, input logic [5:0] rs, input logic [5:0] rr, input logic nar,
                         output logic [63:0] m, output logic res,
                         output string mtag, output string rtag);
        int code = {25'd0, n, ~rs};
        int len = -1;
        for (int i = 0; i < 7; i++) if (code[i]) len = i;
        m = '0;
        if (len < 1) begin
            res = 1'b1; mtag = "R7"; rtag = "R7";
        end else begin
            int esize = 1 << len;
            int s = int'(rs) % esize;
            int r = int'(rr) % esize;
            for (int b = 0; b < 64; b++) begin
                int src = ((b % esize) + r) % esize;
                m[b] = (src <= s);
            end
            res = (s == esize - 1) || (nar && n);
            if (nar) m[63:32] = '0;
            if (nar) mtag = "R6";
            else if (s == esize - 1) mtag = "R5";
            else if (r == 0) mtag = "R2";
            else if (esize == 64) mtag = "R3";
            else mtag = "R4";
            if (nar && n) rtag = "R9";
            else if (s == esize - 1) rtag = "R8";
            else rtag = "R1";
        end
    endtask

    task automatic apply(input logic n, input logic [5:0] rs, input logic [5:0] rr, input logic nar);
        @(negedge clk);
        in_valid = 1'b1; size_hi = n; run_len_code = rs; rot_code = rr; narrow_mode = nar;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_and_compare(input logic n, input logic [5:0] rs, input logic [5:0] rr, input logic nar);
        logic [63:0] em;
        logic er;
        string mt, rt;
        model(n, rs, rr, nar, em, er, mt, rt);
        apply(n, rs, rr, nar);
        chk(mt, pattern_o, em);
        chk(rt, {63'd0, reserved_o}, {63'd0, er});
        chk("R10", {63'd0, out_valid}, 64'd1);
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R10 reset pattern", pattern_o, 64'd0);
        chk("R10 reset reserved", {63'd0, reserved_o}, 64'd0);
        rst_n = 1'b1;

        apply(1'b0, 6'b111100, 6'd0, 1'b0);
        chk("R1 two-bit element", pattern_o, 64'h5555_5555_5555_5555);
        apply(1'b1, 6'd3, 6'd0, 1'b0);
        chk("R2 zero rotate", pattern_o, 64'h0000_0000_0000_000F);
        apply(1'b1, 6'd0, 6'd1, 1'b0);
        chk("R3 rotate by one", pattern_o, 64'h8000_0000_0000_0000);
        apply(1'b0, 6'b100001, 6'd0, 1'b0);
        chk("R4 16-bit copies", pattern_o, 64'h0003_0003_0003_0003);
        apply(1'b1, 6'd63, 6'd5, 1'b0);
        chk("R5 full run", pattern_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R8 full run reserved", {63'd0, reserved_o}, 64'd1);
        apply(1'b0, 6'd0, 6'd0, 1'b1);
        chk("R6 narrow truncation", pattern_o, 64'h0000_0000_0000_0001);
        apply(1'b0, 6'd63, 6'd0, 1'b0);
        chk("R7 zero code pattern", pattern_o, 64'd0);
        chk("R7 zero code reserved", {63'd0, reserved_o}, 64'd1);
        apply(1'b1, 6'd2, 6'd0, 1'b1);
        chk("R9 narrow with size_hi", {63'd0, reserved_o}, 64'd1);

        apply(1'b0, 6'b111100, 6'd0, 1'b0);
        held = pattern_o;
        @(negedge clk);
        in_valid = 1'b0; size_hi = 1'b1; run_len_code = 6'd7; rot_code = 6'd9; narrow_mode = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R10 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R11 hold pattern", pattern_o, held);
        chk("R11 hold reserved", {63'd0, reserved_o}, 64'd0);

        for (int nar = 0; nar < 2; nar++) begin
            for (int code = 0; code < 8192; code++) begin
                logic [12:0] c = 13'(code);
                apply_and_compare(c[12], c[5:0], c[11:6], 1'(nar));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule